// File: doc/BRIEF.md
# Slackness-Driven Stable Matching Crossbar Scheduler

This block decides, once per fabric timeslot, which input port of a small crossbar may send to which output port. Each input offers one request per destination queue: a valid bit, a slackness value (0 is most urgent, and a smaller value means more urgent) and an arrival timestamp for the head cell. The inputs rank outputs by urgency and the outputs rank inputs by age. A proposal-and-acceptance stable matching then runs over several clock cycles and yields a conflict-free input-to-output pairing.

The fabric runs at twice the line rate, so a single `start` begins two matching rounds back to back. The first round uses the requests captured at `start`. The second round uses the same requests with the pairs served in the first round removed. Each round ends with a one-cycle `done` strobe, and `done_round` tells which round the strobe belongs to. The grant outputs hold their value until the next `done`.

Top module: `slack_match_sched`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), `grant_valid` is all zero and `done` is low.
- R2: Each input proposes to its valid, not-yet-rejected destinations in rising slackness order, and equal slackness goes to the lower output index first. The request for input i and output j sits at flat index i*N+j: valid bit i*N+j, slackness bits [(i*N+j)*SW +: SW], timestamp bits [(i*N+j)*TW +: TW].
- R3: An output holds the proposer whose request has the smallest timestamp, and an equal timestamp goes to the lower input index. A displaced or refused input is never granted that output again within the round.
- R4: A round's grants form a stable matching. There is no valid pair (i,j), left unpaired, for which input i prefers j under R2 and output j prefers i under R3 over their current partners (or has none).
- R5: Grants form a partial permutation. No output port value appears on two inputs with `grant_valid` set. Input i's output is in bits [i*PW +: PW] of `grant_port`.
- R6: An input is granted only an output whose request was valid. An input with no valid request receives no grant.
- R7: One `start` yields two rounds. `done_round` is 0 on the first `done` and 1 on the second. The second round's requests are the first round's requests minus the pairs granted in the first round.
- R8: `done` is high for one cycle per round. Each `done` comes at most N*N+1 cycles after the accepted `start` edge or after the previous round's `done`. The grant outputs change only together with `done`.
- R9: Requests are captured at the accepted `start`. A `start`, or a change on the request inputs, while a match is in progress has no effect on either round's grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a two-round match (ignored while busy) |
| voq_valid | input | N*N | Request valid, index i*N+j |
| voq_slack | input | N*N*SW | Request slackness, 0 is most urgent |
| voq_stamp | input | N*N*TW | Request arrival timestamp, smaller is older |
| grant_valid | output | N | Input i holds a grant |
| grant_port | output | N*PW | Granted output per input |
| done | output | 1 | One-cycle end-of-round strobe |
| done_round | output | 1 | 0 for the first round, 1 for the second |

## Verification
The bench builds the block with N=4, SW=4 and TW=6. It draws slackness only from 0..3 and timestamps from 0..7, so ties on both sides are frequent and both index tie-break rules get exercised. Four ports give enough contention for chains of displacement, where one input is bumped several times and its next choice in turn bumps another input. Both rounds are compared against a reference matching computed in the bench and are also checked for blocking pairs. Directed cases add empty requests, all-equal keys, a single active input, heavy contention on one output and a restart attempt in mid-match.

// File: rtl/slack_match_pkg.sv
// Shared types for the slackness-driven stable matching scheduler.
package slack_match_pkg;
    // Sequencer phase: idle, or running the first or second round of a slot.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FIRST  = 2'd1,
        PH_SECOND = 2'd2
    } phase_e;
endpackage

// File: rtl/ssm_input_pick.sv
// Chooses the most urgent candidate output for one input.
// Assumes: cand marks outputs still open to this input; slack_row holds
// N fields of SW bits, field j for output j. Ties go to the lower index.
module ssm_input_pick #(
    parameter int N  = 4,
    parameter int SW = 4,
    parameter int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    cand,
    input  logic [N*SW-1:0] slack_row,
    output logic            has,
    output logic [PW-1:0]   best
);
    logic [SW-1:0] best_slack;

    // Linear scan keeping the strictly smallest slackness seen so far.
    always_comb begin
        has        = 1'b0;
        best       = '0;
        best_slack = '0;
        for (int j = 0; j < N; j++) begin
            if (cand[j] && (!has || slack_row[j*SW +: SW] < best_slack)) begin
                has        = 1'b1;
                best       = PW'(j);
                best_slack = slack_row[j*SW +: SW];
            end
        end
    end
endmodule

// File: rtl/ssm_output_judge.sv
// Decides whether an output accepts a new proposer over its current holder.
// Assumes: an older (smaller) timestamp wins; equal stamps go to the lower
// input index. A free output always accepts.
module ssm_output_judge #(
    parameter int TW = 6,
    parameter int PW = 2
) (
    input  logic          held,
    input  logic [TW-1:0] stamp_new,
    input  logic [TW-1:0] stamp_old,
    input  logic [PW-1:0] idx_new,
    input  logic [PW-1:0] idx_old,
    output logic          take
);
    // Acceptance rule for one proposal.
    always_comb begin
        take = !held
            || (stamp_new < stamp_old)
            || ((stamp_new == stamp_old) && (idx_new < idx_old));
    end
endmodule

// File: rtl/ssm_match_core.sv
// Proposal engine: one proposal per cycle until no free input has a
// candidate left. clear wipes the tentative matching synchronously.
// Assumes: request fields stay stable while run is high.
module ssm_match_core #(
    parameter int N  = 4,
    parameter int SW = 4,
    parameter int TW = 6,
    parameter int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              run,
    input  logic [N*N-1:0]    valid,
    input  logic [N*N*SW-1:0] slack,
    input  logic [N*N*TW-1:0] stamp,
    output logic              no_proposer,
    output logic [N-1:0]      matched,
    output logic [N*PW-1:0]   match_port
);
    localparam int NN = N * N;

    logic [NN-1:0] rej_q;
    logic [N-1:0]  matched_q;
    logic [N-1:0]  held_q;
    logic [PW-1:0] owner_q [N];
    logic [PW-1:0] port_q  [N];

    logic [N-1:0]  has_c;
    logic [PW-1:0] best_c [N];
    logic          found;
    logic [PW-1:0] prop, tgt, holder;
    logic          tgt_held, take;
    logic [TW-1:0] stamp_p, stamp_h;
    int            p_idx, h_idx;

    // One preference picker per input over its still-open requests.
    for (genvar gi = 0; gi < N; gi++) begin : g_pick
        ssm_input_pick #(.N(N), .SW(SW), .PW(PW)) u_pick (
            .cand      (valid[gi*N +: N] & ~rej_q[gi*N +: N]),
            .slack_row (slack[gi*N*SW +: N*SW]),
            .has       (has_c[gi]),
            .best      (best_c[gi])
        );
        assign match_port[gi*PW +: PW] = port_q[gi];
    end

    // Select the lowest-index free input that still has a candidate.
    always_comb begin
        found = 1'b0;
        prop  = '0;
        for (int i = 0; i < N; i++) begin
            if (!found && !matched_q[i] && has_c[i]) begin
                found = 1'b1;
                prop  = PW'(i);
            end
        end
    end

    // Gather the proposal target, its holder and both timestamps.
    always_comb begin
        tgt      = best_c[prop];
        holder   = owner_q[tgt];
        tgt_held = held_q[tgt];
        p_idx    = int'(prop) * N + int'(tgt);
        h_idx    = int'(holder) * N + int'(tgt);
        stamp_p  = stamp[p_idx*TW +: TW];
        stamp_h  = stamp[h_idx*TW +: TW];
    end

    ssm_output_judge #(.TW(TW), .PW(PW)) u_judge (
        .held      (tgt_held),
        .stamp_new (stamp_p),
        .stamp_old (stamp_h),
        .idx_new   (prop),
        .idx_old   (holder),
        .take      (take)
    );

    // Apply one proposal: accept (possibly displacing) or refuse.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            rej_q     <= '0;
            matched_q <= '0;
            held_q    <= '0;
            for (int k = 0; k < N; k++) begin
                owner_q[k] <= '0;
                port_q[k]  <= '0;
            end
        end else if (run && found) begin
            if (take) begin
                held_q[tgt]     <= 1'b1;
                owner_q[tgt]    <= prop;
                matched_q[prop] <= 1'b1;
                port_q[prop]    <= tgt;
                if (tgt_held) begin
                    matched_q[holder] <= 1'b0;
                    rej_q[h_idx]      <= 1'b1;
                end
            end else begin
                rej_q[p_idx] <= 1'b1;
            end
        end
    end

    assign no_proposer = !found;
    assign matched     = matched_q;
endmodule

// File: rtl/slack_match_sched.sv
// Two-round stable matching scheduler for a speedup-2 crossbar.
// Captures requests on an idle start, runs round one, removes the pairs it
// served, runs round two, and strobes done after each round.
// Assumes: synchronous active-low reset; start is ignored while busy.
module slack_match_sched
    import slack_match_pkg::*;
#(
    parameter int N  = 4,
    parameter int SW = 4,
    parameter int TW = 6,
    parameter int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [N*N-1:0]    voq_valid,
    input  logic [N*N*SW-1:0] voq_slack,
    input  logic [N*N*TW-1:0] voq_stamp,
    output logic [N-1:0]      grant_valid,
    output logic [N*PW-1:0]   grant_port,
    output logic              done,
    output logic              done_round
);
    localparam int NN = N * N;

    phase_e             phase_q;
    logic [NN-1:0]      valid_q;
    logic [NN*SW-1:0]   slack_q;
    logic [NN*TW-1:0]   stamp_q;
    logic               core_idle, core_clear, core_run, finishing;
    logic [N-1:0]       core_matched;
    logic [N*PW-1:0]    core_port;
    logic [NN-1:0]      served;

    assign core_run   = (phase_q != PH_IDLE);
    assign finishing  = core_run && core_idle;
    assign core_clear = !core_run || finishing;

    ssm_match_core #(.N(N), .SW(SW), .TW(TW), .PW(PW)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (core_clear),
        .run         (core_run),
        .valid       (valid_q),
        .slack       (slack_q),
        .stamp       (stamp_q),
        .no_proposer (core_idle),
        .matched     (core_matched),
        .match_port  (core_port)
    );

    // Flatten the current matching into a request-indexed mask.
    always_comb begin
        served = '0;
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                if (core_matched[i] && core_port[i*PW +: PW] == PW'(j))
                    served[i*N + j] = 1'b1;
    end

    // Phase sequencing, request capture and grant publication.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= PH_IDLE;
            valid_q     <= '0;
            slack_q     <= '0;
            stamp_q     <= '0;
            grant_valid <= '0;
            grant_port  <= '0;
            done        <= 1'b0;
            done_round  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase_q)
                PH_IDLE: if (start) begin
                    valid_q <= voq_valid;
                    slack_q <= voq_slack;
                    stamp_q <= voq_stamp;
                    phase_q <= PH_FIRST;
                end
                PH_FIRST: if (finishing) begin
                    grant_valid <= core_matched;
                    grant_port  <= core_port;
                    done        <= 1'b1;
                    done_round  <= 1'b0;
                    valid_q     <= valid_q & ~served;
                    phase_q     <= PH_SECOND;
                end
                PH_SECOND: if (finishing) begin
                    grant_valid <= core_matched;
                    grant_port  <= core_port;
                    done        <= 1'b1;
                    done_round  <= 1'b1;
                    phase_q     <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/slack_match_checker.sv
// Property checker for slack_match_sched, attached by bind below.
// Mirrors the busy window from the ports only and watches grant legality.
module slack_match_checker #(
    parameter int N  = 4,
    parameter int SW = 4,
    parameter int TW = 6,
    parameter int PW = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [N*N-1:0]    voq_valid,
    input logic [N-1:0]      grant_valid,
    input logic [N*PW-1:0]   grant_port,
    input logic              done,
    input logic              done_round
);
    localparam int LIM = N * N + 1;

    logic          busy_q;
    int            cnt_q;
    logic [N*N-1:0] cap_valid_q, r0_mask_q, cur_mask;
    logic          dup, bad_valid;

    // Pair mask of the current grants, duplicate-output and validity flags.
    always_comb begin
        cur_mask  = '0;
        dup       = 1'b0;
        bad_valid = 1'b0;
        for (int a = 0; a < N; a++) begin
            if (grant_valid[a]) begin
                cur_mask[a*N + int'(grant_port[a*PW +: PW])] = 1'b1;
                if (!cap_valid_q[a*N + int'(grant_port[a*PW +: PW])]) bad_valid = 1'b1;
            end
            for (int b = a + 1; b < N; b++)
                if (grant_valid[a] && grant_valid[b] &&
                    grant_port[a*PW +: PW] == grant_port[b*PW +: PW])
                    dup = 1'b1;
        end
    end

    // Busy window, cycle counter, captured requests and round-one pairs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q      <= 1'b0;
            cnt_q       <= 0;
            cap_valid_q <= '0;
            r0_mask_q   <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q      <= 1'b1;
                cnt_q       <= 0;
                cap_valid_q <= voq_valid;
            end
        end else if (done && done_round) begin
            busy_q <= start;
            cnt_q  <= 0;
            if (start) cap_valid_q <= voq_valid;
        end else if (done) begin
            cnt_q     <= 1;
            r0_mask_q <= cur_mask;
        end else begin
            cnt_q <= cnt_q + 1;
        end
    end

    assert_partial_perm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !dup);
    assert_grant_on_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && busy_q) |-> !bad_valid);
    assert_round_disjoint_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_round && busy_q) |-> ((r0_mask_q & cur_mask) == '0));
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_round) |=> !done);
    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q <= LIM));
    assert_grant_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(grant_valid) || !$stable(grant_port)) |-> done);
endmodule

bind slack_match_sched slack_match_checker #(.N(N), .SW(SW), .TW(TW), .PW(PW)) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .voq_valid   (voq_valid),
    .grant_valid (grant_valid),
    .grant_port  (grant_port),
    .done        (done),
    .done_round  (done_round)
);

// File: tb/slack_match_sched_tb.sv
// Self-checking bench: reference stable matching in bench functions,
// directed corner cases plus seeded random requests.
module slack_match_sched_tb_top;
    localparam int N  = 4;
    localparam int SW = 4;
    localparam int TW = 6;
    localparam int PW = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [N*N-1:0]    voq_valid = '0;
    logic [N*N*SW-1:0] voq_slack = '0;
    logic [N*N*TW-1:0] voq_stamp = '0;
    logic [N-1:0]      grant_valid;
    logic [N*PW-1:0]   grant_port;
    logic              done, done_round;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    bit vv[N][N];
    int sl[N][N];
    int st[N][N];
    int exp_port[N];   // -1 means no grant
    bit mask[N][N];

    always #2.5 clk = ~clk;

    slack_match_sched #(.N(N), .SW(SW), .TW(TW), .PW(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .voq_valid(voq_valid), .voq_slack(voq_slack), .voq_stamp(voq_stamp),
        .grant_valid(grant_valid), .grant_port(grant_port),
        .done(done), .done_round(done_round)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog expired act=%0d exp=<150000", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, expv);
        end
    endtask

    // Input preference: does input i rank output a above output b?
    function automatic bit in_prefers(int i, int a, int b);
        return (sl[i][a] < sl[i][b]) || (sl[i][a] == sl[i][b] && a < b);
    endfunction

    // Output preference: does output j rank input a above input b?
    function automatic bit out_prefers(int j, int a, int b);
        return (st[a][j] < st[b][j]) || (st[a][j] == st[b][j] && a < b);
    endfunction

    // Reference proposer-side matching over requests in mask; fills exp_port.
    function automatic void reference_match();
        int  hold[N];
        bit  refused[N][N];
        bit  progress;
        for (int k = 0; k < N; k++) begin
            exp_port[k] = -1;
            hold[k] = -1;
            for (int m = 0; m < N; m++) refused[k][m] = 1'b0;
        end
        progress = 1'b1;
        while (progress) begin
            progress = 1'b0;
            for (int i = N - 1; i >= 0 && !progress; i--) begin
                if (exp_port[i] < 0) begin
                    int bj = -1;
                    for (int j = 0; j < N; j++)
                        if (mask[i][j] && !refused[i][j] && (bj < 0 || in_prefers(i, j, bj)))
                            bj = j;
                    if (bj >= 0) begin
                        progress = 1'b1;
                        if (hold[bj] < 0) begin
                            hold[bj] = i; exp_port[i] = bj;
                        end else if (out_prefers(bj, i, hold[bj])) begin
                            refused[hold[bj]][bj] = 1'b1;
                            exp_port[hold[bj]] = -1;
                            hold[bj] = i; exp_port[i] = bj;
                        end else begin
                            refused[i][bj] = 1'b1;
                        end
                    end
                end
            end
        end
    endfunction

    function automatic int dut_port(int i);
        return grant_valid[i] ? int'(grant_port[i*PW +: PW]) : -1;
    endfunction

    // Count blocking pairs of the DUT grants against mask.
    function automatic int blocking_pairs();
        int n = 0;
        int owner[N];
        for (int j = 0; j < N; j++) owner[j] = -1;
        for (int i = 0; i < N; i++) if (dut_port(i) >= 0) owner[dut_port(i)] = i;
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                if (mask[i][j] && dut_port(i) != j &&
                    (dut_port(i) < 0 || in_prefers(i, j, dut_port(i))) &&
                    (owner[j] < 0 || out_prefers(j, i, owner[j])))
                    n++;
        return n;
    endfunction

    function automatic int dup_outputs();
        int n = 0;
        for (int a = 0; a < N; a++)
            for (int b = a + 1; b < N; b++)
                if (dut_port(a) >= 0 && dut_port(a) == dut_port(b)) n++;
        return n;
    endfunction

    task automatic drive_requests();
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                voq_valid[i*N + j]        = vv[i][j];
                voq_slack[(i*N+j)*SW +: SW] = SW'(sl[i][j]);
                voq_stamp[(i*N+j)*TW +: TW] = TW'(st[i][j]);
            end
    endtask

    task automatic wait_done(input bit inject, output int cyc);
        cyc = 0;
        while (1) begin
            @(negedge clk);
            cyc++;
            start = 1'b0;
            if (inject && cyc == 2) begin
                start = 1'b1;
                voq_valid = N*N'($urandom);
                voq_slack = '0;
                voq_stamp = '1;
            end
            if (done || cyc > 4 * N * N) break;
        end
    endtask

    task automatic check_round(input int rnd, input int cyc);
        int n_bad = 0;
        reference_match();
        chk(done == 1'b1, "R8", "done seen", int'(done), 1);
        chk(cyc <= N*N + 1, "R8", "round latency", cyc, N*N + 1);
        chk(done_round == rnd[0], "R7", "done_round", int'(done_round), rnd);
        for (int i = 0; i < N; i++) if (dut_port(i) != exp_port[i]) n_bad++;
        chk(n_bad == 0, rnd == 0 ? "R2 R3" : "R7", "inputs off reference", n_bad, 0);
        chk(blocking_pairs() == 0, "R4", "blocking pairs", blocking_pairs(), 0);
        chk(dup_outputs() == 0, "R5", "duplicate outputs", dup_outputs(), 0);
        n_bad = 0;
        for (int i = 0; i < N; i++) if (dut_port(i) >= 0 && !mask[i][dut_port(i)]) n_bad++;
        chk(n_bad == 0, "R6", "grants on invalid request", n_bad, 0);
    endtask

    // One full slot: start, round one, round two; inject exercises R9.
    task automatic run_slot(input bit inject);
        int cyc;
        for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) mask[i][j] = vv[i][j];
        @(negedge clk);
        drive_requests();
        start = 1'b1;
        wait_done(inject, cyc);
        check_round(0, cyc);
        if (inject) chk(dut_port(0) == exp_port[0], "R9", "restart altered grant", dut_port(0), exp_port[0]);
        for (int i = 0; i < N; i++) if (exp_port[i] >= 0) mask[i][exp_port[i]] = 1'b0;
        wait_done(1'b0, cyc);
        check_round(1, cyc);
        @(negedge clk);
        chk(done == 1'b0, "R8", "done after second round", int'(done), 0);
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R9", "no extra slot from ignored start", int'(done), 0);
    endtask

    task automatic fill(input int vmode, input int smode);
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                vv[i][j] = (vmode == 0) ? 1'b0 : (vmode == 1) ? 1'b1
                         : (vmode == 2) ? (i == 2) : bit'($urandom_range(0, 1));
                sl[i][j] = (smode == 0) ? 0 : (smode == 1) ? ((j == 0) ? 0 : 3) : $urandom_range(0, 3);
                st[i][j] = (smode == 0) ? 0 : (smode == 1) ? (N - 1 - i) : $urandom_range(0, 7);
            end
    endtask

    initial begin
        int r1 = $urandom(32'h5eed_1234);
        r1 = 0;
        repeat (4) @(negedge clk);
        chk(grant_valid == '0, "R1", "grant_valid in reset", int'(grant_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(grant_valid == '0, "R1", "grant_valid after reset", int'(grant_valid), 0);
        chk(done == 1'b0, "R1", "done after reset", int'(done), 0);

        fill(0, 0); run_slot(1'b0);           // R6: nothing valid
        chk(grant_valid == '0, "R6", "empty requests grant", int'(grant_valid), 0);
        fill(1, 0); run_slot(1'b0);           // R2 R3: all ties
        chk(dut_port(0) == 1 && dut_port(1) == 0, "R7", "second round tie pairing",
            dut_port(0), 1);
        fill(2, 2); run_slot(1'b0);           // R6: single active input
        fill(1, 1); run_slot(1'b0);           // R3: contention on output 0
        fill(3, 2); run_slot(1'b1);           // R9: restart mid-match
        for (int t = 0; t < 60; t++) begin
            fill(3, 2);
            run_slot(1'b0);
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule